// File: doc/BRIEF.md
# SPI Data FIFO Pair with Threshold Flags

This block holds the data that moves between a host register interface and a serial shift engine. It has two byte-organised queues. The transmit queue is filled by the host and drained by the shifter. The receive queue is filled by the shifter and drained by the host. A single mode input sets the transfer unit for both queues to either one byte or one 32-bit word. Words are little-endian: byte 0 of the stream travels in bits 7:0.

Each queue reports its state through flags in one status word:

- full
- empty
- ready, which compares the fill level against a programmable 3-bit threshold
- sticky overflow
- sticky underflow

Software normally programs the receive threshold to bytes-per-unit minus one and the transmit threshold to seven minus bytes-per-unit. A flush command empties both queues in one step. Its busy bit clears itself, so software can poll it.

The host may push a short final word by giving its valid byte count. The unused byte lanes are then stored as 0xFF.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset, the status word reads both queues empty, neither full, no sticky flag set and the flush not busy. Status bit positions are: transmit full 0, empty 1, ready 2, overflow 3, underflow 4; receive full 5, empty 6, ready 7, overflow 8, underflow 9.
- R2: In word mode (`word_mode_i`=1) each queue holds two 32-bit entries. They come out in push order. Full is set once two are held.
- R3: In byte mode each queue holds eight bytes, and the shifter sees the head byte in bits 7:0 with zeros above. A word pushed in word mode and read out in byte mode yields its bytes from bits 7:0 upward.
- R4: A host push with `host_nbytes_i` = n, where n is 1 to 3, stores byte lanes n and above as 0xFF. The value 0 means all four lanes are valid.
- R5: Transmit ready is set exactly when free bytes exceed `wr_thr_i`.
- R6: Receive ready is set exactly when held bytes exceed `rd_thr_i`.
- R7: A push into a full queue is dropped and sets that queue's overflow flag. The flag stays set until a flush or reset.
- R8: A pop from an empty queue is dropped and sets that queue's underflow flag. The flag stays set until a flush or reset.
- R9: A flush request sets the busy bit on the next edge. The edge after that empties both queues, clears all sticky flags and clears busy.
- R10: The receive queue takes shifter words and hands them to the host in order, with its own full and overflow flags.
- R11: A push and a pop in the same cycle on a non-full, non-empty queue both take effect, and the fill level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 selects 4-byte units, 0 selects 1-byte units |
| wr_thr_i | input | 3 | Transmit ready threshold (free bytes) |
| rd_thr_i | input | 3 | Receive ready threshold (held bytes) |
| flush_req_i | input | 1 | Flush command |
| flush_busy_o | output | 1 | Flush in progress, clears itself |
| host_push_i | input | 1 | Host writes one unit to the transmit queue |
| host_wdata_i | input | 32 | Host write data, little-endian |
| host_nbytes_i | input | 2 | Valid bytes of a word push (0 means 4) |
| host_pop_i | input | 1 | Host reads one unit from the receive queue |
| host_rdata_o | output | 32 | Head unit of the receive queue |
| sh_pop_i | input | 1 | Shifter takes one unit from the transmit queue |
| sh_wdata_o | output | 32 | Head unit of the transmit queue |
| sh_push_i | input | 1 | Shifter delivers one unit to the receive queue |
| sh_rdata_i | input | 32 | Shifter receive data |
| status_o | output | 10 | Flag word, bit layout as in R1 |

## Verification
The bench fills each queue to capacity and pushes once more. A design that stores the extra word would hand it to the shifter, and one with a non-sticky flag would drop overflow on the next cycle. It writes a word in word mode and drains it byte by byte. A reversed lane order or a wrong pointer step would show the bytes out of order. Short final words check the 0xFF padding, which a careless design would fill with zero or stale data. Thresholds are checked one byte either side of the switch point, so an off-by-one compare shows up, and a flush with data present must leave the reset status two edges after the request.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic udf;
    logic ovf;
    logic ready;
    logic empty;
    logic full;
  } fifo_flags_t;
endpackage

// File: rtl/spi_flush_ctrl.sv
module spi_flush_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clear_o,
  output logic busy_o
);
  logic busy_q;

  // one pending cycle, then the clear edge drops busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (busy_q) busy_q <= 1'b0;
    else             busy_q <= req_i;
  end

  assign clear_o = busy_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  parameter bit READY_ON_FREE = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int NB_W  = $clog2(LANES),
  localparam int DW    = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              word_mode_i,
  input  logic [PTR_W-1:0]  thr_i,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic [NB_W-1:0]   push_nbytes_i,
  input  logic              pop_i,
  output logic [DW-1:0]     head_o,
  output fifo_flags_t       flags_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [BYTE_W-1:0] lane_byte [LANES];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, unit, free, level, add_v, sub_v;
  logic              full, empty, push_ok, pop_ok, ovf_q, udf_q;

  assign unit    = word_mode_i ? CNT_W'(LANES) : CNT_W'(1);
  assign free    = CNT_W'(DEPTH) - cnt_q;
  assign full    = free < unit;
  assign empty   = cnt_q < unit;
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty;
  assign add_v   = push_ok ? unit : '0;
  assign sub_v   = pop_ok ? unit : '0;
  assign level   = READY_ON_FREE ? free : cnt_q;

  // short word: lanes at or above the count are padded with ones
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (push_nbytes_i == '0 || k < int'(push_nbytes_i))
        lane_byte[k] = push_data_i[BYTE_W*k +: BYTE_W];
      else
        lane_byte[k] = '1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i) begin
      if (word_mode_i) begin
        for (int k = 0; k < LANES; k++)
          mem_q[wr_ptr_q + PTR_W'(k)] <= lane_byte[k];
      end else begin
        mem_q[wr_ptr_q] <= push_data_i[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + unit[PTR_W-1:0];
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + unit[PTR_W-1:0];
      cnt_q <= cnt_q + add_v - sub_v;
      if (push_i && full) ovf_q <= 1'b1;
      if (pop_i && empty) udf_q <= 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (word_mode_i || k == 0)
        head_o[BYTE_W*k +: BYTE_W] = mem_q[rd_ptr_q + PTR_W'(k)];
      else
        head_o[BYTE_W*k +: BYTE_W] = '0;
    end
  end

  assign flags_o.full  = full;
  assign flags_o.empty = empty;
  assign flags_o.ready = level > CNT_W'(thr_i);
  assign flags_o.ovf   = ovf_q;
  assign flags_o.udf   = udf_q;
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int THR_W = $clog2(DEPTH),
  localparam int NB_W  = $clog2(LANES),
  localparam int DW    = BYTE_W * LANES,
  localparam int ST_W  = 2 * $bits(fifo_flags_t)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_mode_i,
  input  logic [THR_W-1:0] wr_thr_i,
  input  logic [THR_W-1:0] rd_thr_i,
  input  logic             flush_req_i,
  output logic             flush_busy_o,
  input  logic             host_push_i,
  input  logic [DW-1:0]    host_wdata_i,
  input  logic [NB_W-1:0]  host_nbytes_i,
  input  logic             host_pop_i,
  output logic [DW-1:0]    host_rdata_o,
  input  logic             sh_pop_i,
  output logic [DW-1:0]    sh_wdata_o,
  input  logic             sh_push_i,
  input  logic [DW-1:0]    sh_rdata_i,
  output logic [ST_W-1:0]  status_o
);
  logic        clear;
  fifo_flags_t tx_flags, rx_flags;

  spi_flush_ctrl u_flush (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (flush_req_i),
    .clear_o (clear),
    .busy_o  (flush_busy_o)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .READY_ON_FREE(1'b1)) u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .word_mode_i   (word_mode_i),
    .thr_i         (wr_thr_i),
    .push_i        (host_push_i),
    .push_data_i   (host_wdata_i),
    .push_nbytes_i (host_nbytes_i),
    .pop_i         (sh_pop_i),
    .head_o        (sh_wdata_o),
    .flags_o       (tx_flags)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .READY_ON_FREE(1'b0)) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .word_mode_i   (word_mode_i),
    .thr_i         (rd_thr_i),
    .push_i        (sh_push_i),
    .push_data_i   (sh_rdata_i),
    .push_nbytes_i ('0),
    .pop_i         (host_pop_i),
    .head_o        (host_rdata_o),
    .flags_o       (rx_flags)
  );

  assign status_o = {rx_flags, tx_flags};
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flush_busy_o,
  input logic       host_push_i,
  input logic       host_pop_i,
  input logic       sh_push_i,
  input logic [9:0] status_o
);
  // R9
  flush_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |=> !flush_busy_o && status_o[1] && status_o[6] &&
      !status_o[3] && !status_o[4] && !status_o[8] && !status_o[9]);
  // R7
  wr_ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_push_i && status_o[0] && !flush_busy_o |=> status_o[3]);
  // R7
  wr_ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && !flush_busy_o |=> status_o[3]);
  // R10
  rd_ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_push_i && status_o[5] && !flush_busy_o |=> status_o[8]);
  // R8
  rd_udf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_pop_i && status_o[6] && !flush_busy_o |=> status_o[9]);
  // R2
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[0] && status_o[1]) && !(status_o[5] && status_o[6]));
endmodule

bind spi_fifo_pair spi_fifo_pair_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_busy_o (flush_busy_o),
  .host_push_i  (host_push_i),
  .host_pop_i   (host_pop_i),
  .sh_push_i    (sh_push_i),
  .status_o     (status_o)
);

// File: tb/spi_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_mode_i = 1'b1;
  logic [2:0]  wr_thr_i = 3'd3;
  logic [2:0]  rd_thr_i = 3'd3;
  logic        flush_req_i = 1'b0;
  logic        flush_busy_o;
  logic        host_push_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic [1:0]  host_nbytes_i = '0;
  logic        host_pop_i = 1'b0;
  logic [31:0] host_rdata_o;
  logic        sh_pop_i = 1'b0;
  logic [31:0] sh_wdata_o;
  logic        sh_push_i = 1'b0;
  logic [31:0] sh_rdata_i = '0;
  logic [9:0]  status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] wq[$];
  logic [31:0] rq[$];

  always #2 clk_i = ~clk_i;

  spi_fifo_pair dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pad(logic [31:0] d, logic [1:0] nb);
    logic [31:0] r = d;
    for (int k = 1; k < 4; k++)
      if (nb != 0 && k >= int'(nb)) r[8*k +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic host_push(logic [31:0] d, logic [1:0] nb);
    @(negedge clk_i);
    host_push_i = 1; host_wdata_i = d; host_nbytes_i = nb;
    @(negedge clk_i);
    host_push_i = 0; host_nbytes_i = 0;
  endtask

  // scoreboard monitor on the shifter side of the transmit queue
  task automatic sh_pop(string tag);
    @(negedge clk_i);
    if (wq.size() > 0) chk(tag, sh_wdata_o, wq.pop_front());
    sh_pop_i = 1;
    @(negedge clk_i);
    sh_pop_i = 0;
  endtask

  task automatic sh_push(logic [31:0] d);
    @(negedge clk_i);
    sh_push_i = 1; sh_rdata_i = d;
    @(negedge clk_i);
    sh_push_i = 0;
  endtask

  task automatic host_pop(string tag);
    @(negedge clk_i);
    if (rq.size() > 0) chk(tag, host_rdata_o, rq.pop_front());
    host_pop_i = 1;
    @(negedge clk_i);
    host_pop_i = 0;
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_req_i = 1;
    @(negedge clk_i);
    flush_req_i = 0;
    chk("R9 busy set", 32'(flush_busy_o), 32'd1);
    @(negedge clk_i);
    chk("R9 busy clear", 32'(flush_busy_o), 32'd0);
    wq.delete(); rq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset status", 32'(status_o), 32'h046);
    chk("R1 flush idle", 32'(flush_busy_o), 32'd0);

    // word mode order and capacity
    host_push(32'h11223344, 0); wq.push_back(32'h11223344);
    chk("R5 ready free4>3", 32'(status_o[2]), 32'd1);
    host_push(32'hAABBCCDD, 0); wq.push_back(32'hAABBCCDD);
    chk("R2 full", 32'(status_o[0]), 32'd1);
    chk("R5 not ready free0", 32'(status_o[2]), 32'd0);
    host_push(32'hDEADBEEF, 0);
    chk("R7 wr overflow", 32'(status_o[3]), 32'd1);
    sh_pop("R2 first word");
    sh_pop("R7 second word, dropped push absent");
    chk("R2 empty", 32'(status_o[1]), 32'd1);
    chk("R7 overflow sticky", 32'(status_o[3]), 32'd1);
    sh_pop("R8 pop on empty");
    chk("R8 wr underflow", 32'(status_o[4]), 32'd1);
    chk("R8 still empty", 32'(status_o[1:0]), 32'd2);

    host_push(32'h01020304, 0);
    do_flush();
    chk("R9 status after flush", 32'(status_o), 32'h046);

    // padding of short words
    host_push(32'h00000055, 1); wq.push_back(pad(32'h00000055, 1));
    host_push(32'h00112233, 3); wq.push_back(pad(32'h00112233, 3));
    sh_pop("R4 pad one byte");
    sh_pop("R4 pad three bytes");

    // word in, bytes out
    host_push(32'h44332211, 0);
    @(negedge clk_i); word_mode_i = 0; wr_thr_i = 3'd6;
    wq.push_back(32'h11); wq.push_back(32'h22);
    wq.push_back(32'h33); wq.push_back(32'h44);
    for (int i = 0; i < 4; i++) sh_pop("R3 little-endian bytes");
    chk("R3 empty after bytes", 32'(status_o[1]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      host_push(32'hA0 + 32'(i), 0); wq.push_back(32'hA0 + 32'(i));
      if (i == 0) chk("R5 ready free7>6", 32'(status_o[2]), 32'd1);
      if (i == 1) chk("R5 not ready free6", 32'(status_o[2]), 32'd0);
    end
    chk("R3 full at eight bytes", 32'(status_o[0]), 32'd1);
    for (int i = 0; i < 8; i++) sh_pop("R3 byte order");

    // receive queue
    @(negedge clk_i); word_mode_i = 1; wr_thr_i = 3'd3;
    chk("R6 rx not ready", 32'(status_o[7]), 32'd0);
    sh_push(32'hCAFE0001); rq.push_back(32'hCAFE0001);
    chk("R6 rx ready 4>3", 32'(status_o[7]), 32'd1);
    sh_push(32'hCAFE0002); rq.push_back(32'hCAFE0002);
    chk("R10 rx full", 32'(status_o[5]), 32'd1);
    sh_push(32'hCAFE0003);
    chk("R10 rx overflow", 32'(status_o[8]), 32'd1);
    host_pop("R10 rx first");
    host_pop("R10 rx second");
    host_pop("R8 rx pop empty");
    chk("R8 rx underflow", 32'(status_o[9]), 32'd1);
    do_flush();
    @(negedge clk_i); word_mode_i = 0; rd_thr_i = 3'd0;
    sh_push(32'h0000005A); rq.push_back(32'h5A);
    chk("R6 rx byte ready 1>0", 32'(status_o[7]), 32'd1);
    host_pop("R6 rx byte value");

    // simultaneous push and pop
    @(negedge clk_i); word_mode_i = 1; rd_thr_i = 3'd3;
    host_push(32'h0000BEEF, 0); wq.push_back(32'h0000BEEF);
    @(negedge clk_i);
    chk("R11 head before", sh_wdata_o, wq.pop_front());
    host_push_i = 1; host_wdata_i = 32'h0000F00D; sh_pop_i = 1;
    @(negedge clk_i);
    host_push_i = 0; sh_pop_i = 0; wq.push_back(32'h0000F00D);
    chk("R11 level kept", 32'(status_o[1:0]), 32'd0);
    sh_pop("R11 new word");
    chk("R11 empty after", 32'(status_o[1]), 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule